// File: doc/BRIEF.md
# Multiplexed Byte-Lane Bus Target

This block is the target side of a narrow synchronous backplane bus where address, control and data share one byte-wide lane. A tenure opens with a one-cycle frame marker. In that first cycle the four arbitration lines carry the logical address of the card being called, and the value 0 calls every card at once. The target recognises its own address, or a broadcast, in that cycle. Over the next two cycles it gathers the transfer mode, the length and a 24-bit physical address. It then answers at fixed cycle positions with presence, readiness and an out-of-window flag.

Behind the bus sits a byte-wide local store that covers a fixed address window and returns read data a parameterised number of cycles after each request. Writes and block writes move bytes from the lane into consecutive store locations. Reads return bytes, each marked by a data-valid strobe. A read-modify-write returns the bytes and then takes the master's modified copy back. After a broadcast write, the card drives a single acknowledge bit during one of two acknowledge cycles. Its card index selects both the cycle and the bit.

Top module: `slv_target`

States: IDLE waits for a frame marker that names this card. HDR2 and HDR3 gather the header. WDAT takes write bytes. ACK0 and ACK1 are the two broadcast acknowledge cycles. RREQ issues one store read. RWAIT waits for that byte and strobes it out. RMWW takes the write-back bytes of a read-modify-write. The transitions are:
- IDLE→HDR2 on a hit.
- HDR2→HDR3 always.
- HDR3→WDAT for write and block modes, and HDR3→RREQ for read and read-modify-write.
- WDAT→IDLE on the last byte, or WDAT→ACK0 on the last byte of a broadcast.
- ACK0→ACK1→IDLE.
- RREQ→IDLE on a violation, otherwise RREQ→RWAIT.
- RWAIT→RREQ after a byte that is not the last.
- RWAIT→IDLE or RWAIT→RMWW after the last byte.
- RMWW→IDLE after its last byte.

## Requirements
- R1: While reset is held and in the first cycle after it, ad_oe and stat_oe are low.
- R2: A frame is taken only if arb_in in the marker cycle equals LOG_ADDR, or equals 0 with mode write or block. For any other frame the card drives nothing and the store is unchanged.
- R3: Mode comes from ctl_in in cycle 1, with 00 read, 01 write, 10 read-modify-write and 11 block. Address bits 23:16, 15:8 and 7:0 come from ad_in in cycles 1, 2 and 3. For modes other than block, ctl_in in cycle 2 is a length code giving code+1 bytes.
- R4: In cycle 3 of a taken frame, stat_oe is high, stat_out[0] (present) is 1 and stat_out[1] (ready) is 1.
- R5: In cycle 4, stat_oe is high and stat_out[0] is 1 exactly when some byte of the transfer falls outside [WIN_BASE, WIN_BASE+WIN_SIZE).
- R6: A write stores the ad_in bytes of cycles 4, 5 and onward at consecutive addresses from the captured address. A write with a violation stores nothing.
- R7: A read returns each byte on ad_out with ad_oe, stat_oe and stat_out = 10. The first byte comes in cycle 4+MEM_LAT, and each later byte comes MEM_LAT+1 cycles after the one before.
- R8: A read with a violation returns no data strobe.
- R9: In a read-modify-write, the n cycles after the last strobe carry bytes that are stored at the same addresses.
- R10: In block mode, the cycle-2 code gives (code+2)*4 bytes, so 8, 12, 16 or 20.
- R11: After the last byte of a broadcast write, ACK0 and then ACK1 follow. A card with index below 8 drives ad_out = 1<<index in ACK0. Any other card drives 1<<(index-8) in ACK1. No bit is driven if the write had a violation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_start | input | 1 | Marks cycle 1 of a tenure |
| arb_in | input | 4 | Arbitration lines, logical address in cycle 1 |
| ctl_in | input | 2 | Control lines: mode in cycle 1, length in cycle 2 |
| ad_in | input | 8 | Multiplexed address/data lane from the master |
| ad_out | output | 8 | Lane value driven by this card |
| ad_oe | output | 1 | This card drives the lane |
| stat_out | output | 2 | Status lines: present/ready, violation, data valid |
| stat_oe | output | 1 | This card drives the status lines |

## Verification
In cycle 4, the violation report falls in the same cycle as the first write byte being captured, or as the first store read being issued. The bench provokes this with a write that starts two bytes below the window end but runs four bytes long. It judges the result in two ways: it checks the cycle-4 flag, and it reads back the in-window part to confirm that nothing was stored. A second case sets the end of a read-modify-write's strobes right against the start of its write-back. A scoreboard then confirms that the bytes read afterwards are the retransmitted ones.

// File: rtl/slv_pkg.sv
package slv_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_HDR2,
        ST_HDR3,
        ST_WDAT,
        ST_ACK0,
        ST_ACK1,
        ST_RREQ,
        ST_RWAIT,
        ST_RMWW
    } slv_state_e;

    typedef enum logic [1:0] {
        MD_READ  = 2'b00,
        MD_WRITE = 2'b01,
        MD_RMW   = 2'b10,
        MD_BLOCK = 2'b11
    } slv_mode_e;

    typedef struct packed {
        logic [23:0] addr;
        slv_mode_e   mode;
        logic [1:0]  lcode;
        logic        bcast;
    } slv_hdr_t;

    function automatic logic [4:0] xfer_bytes(slv_mode_e m, logic [1:0] code);
        logic [2:0] quads;
        quads = {1'b0, code} + 3'd2;
        if (m == MD_BLOCK) return {quads, 2'b00};
        return {3'b000, code} + 5'd1;
    endfunction

endpackage

// File: rtl/slv_window.sv
module slv_window #(
    parameter logic [23:0] WIN_BASE = 24'h001000,
    parameter int          WIN_SIZE = 256,
    localparam int         AW       = $clog2(WIN_SIZE)
) (
    input  logic [23:0]   addr,
    input  logic [4:0]    nbytes,
    output logic          viol,
    output logic [AW-1:0] off
);
    logic [24:0] diff;
    logic [24:0] endp;

    always_comb begin
        diff = {1'b0, addr} - {1'b0, WIN_BASE};
        endp = {1'b0, diff[23:0]} + {20'd0, nbytes};
        viol = diff[24] || (endp > 25'(WIN_SIZE));
        off  = diff[AW-1:0];
    end
endmodule

// File: rtl/slv_localmem.sv
module slv_localmem #(
    parameter int DEPTH   = 256,
    parameter int LATENCY = 2,
    localparam int AW     = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic          re,
    input  logic [AW-1:0] addr,
    input  logic [7:0]    wdata,
    output logic          rvld,
    output logic [7:0]    rdata
);
    logic [7:0] store [DEPTH];
    logic       vld_q [LATENCY];
    logic [7:0] dat_q [LATENCY];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) store[i] <= 8'h00;
        end else if (we) begin
            store[addr] <= wdata;
        end
    end

    for (genvar g = 0; g < LATENCY; g++) begin : g_stage
        if (g == 0) begin : g_head
            always_ff @(posedge clk) begin
                if (!rst_n) vld_q[0] <= 1'b0;
                else        vld_q[0] <= re;
                dat_q[0] <= store[addr];
            end
        end else begin : g_tail
            always_ff @(posedge clk) begin
                if (!rst_n) vld_q[g] <= 1'b0;
                else        vld_q[g] <= vld_q[g-1];
                dat_q[g] <= dat_q[g-1];
            end
        end
    end

    assign rvld  = vld_q[LATENCY-1];
    assign rdata = dat_q[LATENCY-1];
endmodule

// File: rtl/slv_target.sv
module slv_target
    import slv_pkg::*;
#(
    parameter logic [3:0]  LOG_ADDR = 4'd5,
    parameter int          CARD_IDX = 11,
    parameter logic [23:0] WIN_BASE = 24'h001000,
    parameter int          WIN_SIZE = 256,
    parameter int          MEM_LAT  = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       frame_start,
    input  logic [3:0] arb_in,
    input  logic [1:0] ctl_in,
    input  logic [7:0] ad_in,
    output logic [7:0] ad_out,
    output logic       ad_oe,
    output logic [1:0] stat_out,
    output logic       stat_oe
);
    localparam int         AW       = $clog2(WIN_SIZE);
    localparam logic [2:0] ACK_BIT  = 3'(CARD_IDX % 8);
    localparam bit         ACK_LATE = (CARD_IDX >= 8);

    slv_state_e    state_q, state_d;
    slv_hdr_t      hdr_q, hdr_d;
    logic [4:0]    idx_q, idx_d;
    logic          c4_q;
    logic [4:0]    nbytes;
    logic          last_byte;
    logic          hit;
    logic          viol;
    logic [AW-1:0] off;
    logic [AW-1:0] mem_addr;
    logic          mem_we, mem_re, mem_vld;
    logic [7:0]    mem_rdata;

    assign nbytes    = xfer_bytes(hdr_q.mode, hdr_q.lcode);
    assign last_byte = (idx_q == nbytes - 5'd1);
    assign hit       = (arb_in == LOG_ADDR) || (arb_in == 4'd0 && ctl_in[0]);
    assign mem_addr  = off + AW'(idx_q);

    slv_window #(.WIN_BASE(WIN_BASE), .WIN_SIZE(WIN_SIZE)) u_win (
        .addr   (hdr_q.addr),
        .nbytes (nbytes),
        .viol   (viol),
        .off    (off)
    );

    slv_localmem #(.DEPTH(WIN_SIZE), .LATENCY(MEM_LAT)) u_mem (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (mem_we),
        .re    (mem_re),
        .addr  (mem_addr),
        .wdata (ad_in),
        .rvld  (mem_vld),
        .rdata (mem_rdata)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            hdr_q   <= '0;
            idx_q   <= '0;
            c4_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            hdr_q   <= hdr_d;
            idx_q   <= idx_d;
            c4_q    <= (state_q == ST_HDR3);
        end
    end

    always_comb begin
        state_d = state_q;
        hdr_d   = hdr_q;
        idx_d   = idx_q;
        mem_we  = 1'b0;
        mem_re  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                idx_d = '0;
                if (frame_start && hit) begin
                    hdr_d.addr[23:16] = ad_in;
                    hdr_d.mode        = slv_mode_e'(ctl_in);
                    hdr_d.bcast       = (arb_in == 4'd0);
                    state_d           = ST_HDR2;
                end
            end
            ST_HDR2: begin
                hdr_d.addr[15:8] = ad_in;
                hdr_d.lcode      = ctl_in;
                state_d          = ST_HDR3;
            end
            ST_HDR3: begin
                hdr_d.addr[7:0] = ad_in;
                if (hdr_q.mode == MD_READ || hdr_q.mode == MD_RMW) state_d = ST_RREQ;
                else                                               state_d = ST_WDAT;
            end
            ST_WDAT: begin
                mem_we = !viol;
                idx_d  = idx_q + 5'd1;
                if (last_byte) begin
                    idx_d   = '0;
                    state_d = hdr_q.bcast ? ST_ACK0 : ST_IDLE;
                end
            end
            ST_ACK0: state_d = ST_ACK1;
            ST_ACK1: state_d = ST_IDLE;
            ST_RREQ: begin
                if (viol) begin
                    state_d = ST_IDLE;
                end else begin
                    mem_re  = 1'b1;
                    state_d = ST_RWAIT;
                end
            end
            ST_RWAIT: begin
                if (mem_vld) begin
                    if (last_byte) begin
                        idx_d   = '0;
                        state_d = (hdr_q.mode == MD_RMW) ? ST_RMWW : ST_IDLE;
                    end else begin
                        idx_d   = idx_q + 5'd1;
                        state_d = ST_RREQ;
                    end
                end
            end
            ST_RMWW: begin
                mem_we = !viol;
                idx_d  = idx_q + 5'd1;
                if (last_byte) begin
                    idx_d   = '0;
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        ad_out   = 8'h00;
        ad_oe    = 1'b0;
        stat_out = 2'b00;
        stat_oe  = 1'b0;
        if (state_q == ST_HDR3) begin
            stat_oe  = 1'b1;
            stat_out = 2'b11;
        end
        if (c4_q) begin
            stat_oe  = 1'b1;
            stat_out = {1'b0, viol};
        end
        if (state_q == ST_RWAIT && mem_vld) begin
            stat_oe  = 1'b1;
            stat_out = 2'b10;
            ad_oe    = 1'b1;
            ad_out   = mem_rdata;
        end
        if (!viol && ((state_q == ST_ACK0 && !ACK_LATE) ||
                      (state_q == ST_ACK1 &&  ACK_LATE))) begin
            ad_oe  = 1'b1;
            ad_out = 8'h01 << ACK_BIT;
        end
    end
endmodule

// File: rtl/slv_target_chk.sv
module slv_target_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [7:0] ad_out,
    input logic       ad_oe,
    input logic [1:0] stat_out,
    input logic       stat_oe,
    input logic       mem_we,
    input logic       viol,
    input logic       mem_vld
);
    a_r1_quiet_from_reset: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (!ad_oe && !stat_oe));

    a_r4_flag_follows_presence: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_oe && stat_out == 2'b11 && !ad_oe) |=> (stat_oe && !stat_out[1]));

    a_r6_no_store_when_violated: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> !viol);

    a_r7_strobe_from_store: assert property (@(posedge clk) disable iff (!rst_n)
        (ad_oe && stat_oe) |-> (mem_vld && stat_out == 2'b10));

    a_r11_ack_single_bit: assert property (@(posedge clk) disable iff (!rst_n)
        (ad_oe && !stat_oe) |-> ($countones(ad_out) == 1));
endmodule

bind slv_target slv_target_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ad_out   (ad_out),
    .ad_oe    (ad_oe),
    .stat_out (stat_out),
    .stat_oe  (stat_oe),
    .mem_we   (mem_we),
    .viol     (viol),
    .mem_vld  (mem_vld)
);

// File: tb/tb_slv_target.sv
module tb_slv_target;
    localparam logic [3:0]  LOG  = 4'd5;
    localparam int          CARD = 11;
    localparam logic [23:0] BASE = 24'h001000;
    localparam int          SIZE = 256;
    localparam int          LAT  = 2;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       frame_start;
    logic [3:0] arb_in;
    logic [1:0] ctl_in;
    logic [7:0] ad_in;
    logic [7:0] ad_out;
    logic       ad_oe;
    logic [1:0] stat_out;
    logic       stat_oe;

    int checks = 0;
    int errors = 0;
    logic [7:0] exp_q [$];
    logic [7:0] shadow [SIZE];
    logic [7:0] wbuf [32];
    logic       s_ad_oe, s_stat_oe;
    logic [7:0] s_ad;
    logic [1:0] s_stat;
    bit         done = 0;

    always #10 clk = ~clk;

    slv_target #(.LOG_ADDR(LOG), .CARD_IDX(CARD), .WIN_BASE(BASE),
                 .WIN_SIZE(SIZE), .MEM_LAT(LAT)) dut (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .arb_in(arb_in),
        .ctl_in(ctl_in), .ad_in(ad_in), .ad_out(ad_out), .ad_oe(ad_oe),
        .stat_out(stat_out), .stat_oe(stat_oe));

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic report();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    task automatic cyc(input logic fs, input logic [3:0] arb, input logic [1:0] ctl,
                       input logic [7:0] ad);
        @(negedge clk);
        frame_start = fs; arb_in = arb; ctl_in = ctl; ad_in = ad;
        #1;
        s_ad_oe = ad_oe; s_stat_oe = stat_oe; s_ad = ad_out; s_stat = stat_out;
    endtask

    // Scoreboard monitor: every data strobe pops one expected read byte.
    always @(negedge clk) begin
        #2;
        if (rst_n && ad_oe && stat_oe && stat_out[1]) begin
            if (exp_q.size() == 0) chk("R7", "unexpected strobe", 1, 0);
            else chk("R7", "read byte", int'(ad_out), int'(exp_q.pop_front()));
        end
    end

    task automatic header(input logic [3:0] la, input logic [1:0] md, input logic [23:0] a,
                          input logic [1:0] lc, input bit sel);
        cyc(1'b1, la, md, a[23:16]);
        cyc(1'b0, 4'd0, lc, a[15:8]);
        cyc(1'b0, 4'd0, 2'b00, a[7:0]);
        if (sel) begin
            chk("R4", "cycle3 stat_oe", int'(s_stat_oe), 1);
            chk("R4", "cycle3 present/ready", int'(s_stat), 3);
        end else begin
            chk("R2", "unselected cycle3 drive", int'(s_stat_oe | s_ad_oe), 0);
        end
    endtask

    task automatic write_frame(input logic [3:0] la, input logic [1:0] md, input logic [23:0] a,
                               input logic [1:0] lc, input bit sel, input bit viol);
        int n;
        n = (md == 2'b11) ? (int'(lc) + 2) * 4 : int'(lc) + 1;
        header(la, md, a, lc, sel);
        for (int i = 0; i < n; i++) begin
            cyc(1'b0, 4'd0, 2'b00, wbuf[i]);
            if (i == 0 && sel) begin
                chk("R5", "cycle4 stat_oe", int'(s_stat_oe), 1);
                chk("R5", "cycle4 violation", int'(s_stat[0]), int'(viol));
            end
            if (!sel) chk("R2", "unselected data drive", int'(s_stat_oe | s_ad_oe), 0);
            if (sel && !viol) shadow[int'(a - BASE) + i] = wbuf[i];
        end
        if (la == 4'd0 && sel) begin
            for (int k = 0; k < 2; k++) begin
                bit mine;
                mine = !viol && ((CARD >= 8) == (k == 1));
                cyc(1'b0, 4'd0, 2'b00, 8'h00);
                chk("R11", $sformatf("ack cycle %0d oe", k), int'(s_ad_oe), int'(mine));
                if (mine) chk("R11", "ack bit", int'(s_ad), 1 << (CARD % 8));
            end
        end
        cyc(1'b0, 4'd0, 2'b00, 8'h00);
    endtask

    task automatic read_frame(input bit rmw, input logic [23:0] a, input logic [1:0] lc,
                              input bit viol);
        int n, c, got, last;
        n = int'(lc) + 1;
        if (!viol) for (int i = 0; i < n; i++) exp_q.push_back(shadow[int'(a - BASE) + i]);
        header(LOG, rmw ? 2'b10 : 2'b00, a, lc, 1'b1);
        cyc(1'b0, 4'd0, 2'b00, 8'h00);
        chk("R5", "read cycle4 stat_oe", int'(s_stat_oe), 1);
        chk("R5", "read cycle4 violation", int'(s_stat[0]), int'(viol));
        c = 4; got = 0; last = 0;
        while (got < n && c < 4 + n * (LAT + 1) + 5) begin
            cyc(1'b0, 4'd0, 2'b00, 8'h00);
            c++;
            if (s_ad_oe && s_stat_oe && s_stat[1]) begin
                if (got == 0) chk("R7", "first strobe cycle", c, 4 + LAT);
                else          chk("R7", "strobe spacing", c - last, LAT + 1);
                last = c;
                got++;
            end
        end
        if (viol) chk("R8", "strobes on violated read", got, 0);
        else      chk("R7", "strobe count", got, n);
        if (rmw && !viol) begin
            for (int i = 0; i < n; i++) begin
                cyc(1'b0, 4'd0, 2'b00, wbuf[i]);
                shadow[int'(a - BASE) + i] = wbuf[i];   // R9 write-back
            end
        end
        cyc(1'b0, 4'd0, 2'b00, 8'h00);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            chk("WATCHDOG", "run ended", 0, 1);
            report();
        end
    end

    initial begin
        for (int i = 0; i < SIZE; i++) shadow[i] = 8'h00;
        rst_n = 1'b0; frame_start = 1'b0; arb_in = 4'd0; ctl_in = 2'b00; ad_in = 8'h00;
        repeat (3) @(negedge clk);
        #1 chk("R1", "outputs in reset", int'(ad_oe | stat_oe), 0);
        @(negedge clk); rst_n = 1'b1;
        cyc(1'b0, 4'd0, 2'b00, 8'h00);
        chk("R1", "outputs after reset", int'(s_ad_oe | s_stat_oe), 0);

        // R3 R6: four-byte write, then read-back under different lengths
        for (int i = 0; i < 4; i++) wbuf[i] = 8'hA0 + 8'(i);
        write_frame(LOG, 2'b01, BASE + 24'h10, 2'd3, 1, 0);
        read_frame(0, BASE + 24'h10, 2'd3, 0);
        read_frame(0, BASE + 24'h12, 2'd0, 0);
        read_frame(0, BASE + 24'h11, 2'd2, 0);

        // R2: frame for another card, broadcast read ignored
        for (int i = 0; i < 4; i++) wbuf[i] = 8'h11;
        write_frame(4'd7, 2'b01, BASE + 24'h10, 2'd3, 0, 0);
        header(4'd0, 2'b00, BASE + 24'h10, 2'd0, 0);
        for (int i = 0; i < 6; i++) begin
            cyc(1'b0, 4'd0, 2'b00, 8'h00);
            chk("R2", "broadcast read ignored", int'(s_ad_oe | s_stat_oe), 0);
        end
        read_frame(0, BASE + 24'h10, 2'd3, 0);

        // R5 R6: write running past window end is flagged and discarded
        for (int i = 0; i < 4; i++) wbuf[i] = 8'h55;
        write_frame(LOG, 2'b01, BASE + 24'(SIZE - 2), 2'd3, 1, 1);
        read_frame(0, BASE + 24'(SIZE - 2), 2'd1, 0);

        // R8: read below the window
        read_frame(0, BASE - 24'd1, 2'd0, 1);

        // R10: block of code 1 = 12 bytes
        for (int i = 0; i < 12; i++) wbuf[i] = 8'h30 + 8'(i);
        write_frame(LOG, 2'b11, BASE + 24'h40, 2'd1, 1, 0);
        for (int q = 0; q < 3; q++) read_frame(0, BASE + 24'h40 + 24'(q * 4), 2'd3, 0);

        // R9: read-modify-write of two bytes, then read back
        wbuf[0] = 8'hC1; wbuf[1] = 8'hC2;
        read_frame(1, BASE + 24'h10, 2'd1, 0);
        read_frame(0, BASE + 24'h10, 2'd3, 0);

        // R11: broadcast writes, in window and violated
        wbuf[0] = 8'h9A; wbuf[1] = 8'h9B;
        write_frame(4'd0, 2'b01, BASE + 24'h80, 2'd1, 1, 0);
        read_frame(0, BASE + 24'h80, 2'd1, 0);
        write_frame(4'd0, 2'b01, BASE + 24'(SIZE), 2'd1, 1, 1);

        repeat (4) cyc(1'b0, 4'd0, 2'b00, 8'h00);
        chk("R7", "scoreboard drained", exp_q.size(), 0);
        done = 1;
        report();
    end
endmodule